// File: doc/BRIEF.md
# Serial Multiply-Accumulate FIR Filter with Switchable Coefficient Banks

This block filters a stream of signed 8-bit samples with an 8-tap finite impulse response. It does not use one multiplier per tap. A single signed multiplier and one wide accumulator are shared across all taps, and the taps are processed one per clock cycle. Each accepted sample enters a delay line. A tap counter then steps through the stored samples, multiplies each one by its coefficient and adds the product into the accumulator. When the last tap has been added, a one-cycle strobe presents the finished sum.

Four fixed coefficient banks sit in small computed read-only tables. A 2-bit select input chooses one of them for each output. The select is captured when a sample is accepted and stays fixed for that computation. The block therefore serves front ends that switch filter responses at run time and whose sample rate is at most one sample every nine clock cycles.

Top module: `serial_fir_mac`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears the delay line, the accumulator, the tap counter, `busy`, `result_valid` and `result`, so all three outputs read 0 after that edge.
- R2: A rising edge with `sample_valid` high and `busy` low accepts `sample_in`: the sample becomes delay position 0 (the newest), every older sample moves one position further, and `busy` reads 1 after that edge.
- R3: Eight edges after the accepting edge, `result_valid` is 1 for exactly one cycle and `busy` falls at that same edge. On the seven edges in between, `result_valid` stays 0.
- R4: `result` is the signed 23-bit two's-complement sum over k = 0..7 of delay position k times coefficient k of the selected bank. Samples and coefficients are signed 8-bit values, and each product is sign-extended before it is added.
- R5: The coefficient banks hold these values for tap k: bank 0 holds k+1; bank 1 holds 1 at k=0 and 0 elsewhere; bank 2 holds +64 for even k and -64 for odd k; bank 3 holds -128 at every tap.
- R6: `bank_sel` is sampled only at the accepting edge. A change on it while `busy` is high has no effect on the result being computed.
- R7: A `sample_valid` pulse while `busy` is high is ignored: the delay line is not shifted and the sample never appears in any later result.
- R8: Extreme operands (all stored samples -128 or +127 against bank 3) produce the exact sums +131072 and -130048 without overflow.
- R9: `result` keeps its value from one `result_valid` strobe until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Offers `sample_in` for acceptance |
| sample_in | input | 8 | Signed input sample |
| bank_sel | input | 2 | Coefficient bank index |
| busy | output | 1 | High while the taps of one output are being processed |
| result_valid | output | 1 | One-cycle strobe marking a finished sum |
| result | output | 23 | Signed filter output |

## Verification
The bench builds the block with its default parameters: 8-bit samples and coefficients, 8 taps, 4 banks and a 23-bit accumulator. With these sizes, each bank's formula can be computed exactly in the bench, and the accumulator is only a few bits wider than the largest possible sum of eight products. This makes the all -128 and all +127 delay lines against the -128 bank true boundary cases for sign extension and headroom. Random samples, banks and inter-sample gaps are combined with select changes and rejected sample pulses during busy periods, so the capture of the bank and the protection of the delay line are exercised many times.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

  // Coefficient for a given bank and tap index, as a plain integer.
  // Banks beyond the fourth reuse the four patterns cyclically.
  function automatic int bank_coef(input int bank, input int tap);
    int b;
    b = bank % 4;
    case (b)
      0:       return tap + 1;
      1:       return (tap == 0) ? 1 : 0;
      2:       return (tap % 2 == 0) ? 64 : -64;
      default: return -128;
    endcase
  endfunction

endpackage

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
  parameter int COEF_W = 8,
  parameter int TAPS   = 8,
  parameter int BANK   = 0,
  localparam int ADDR_W = $clog2(TAPS)
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [COEF_W-1:0] coef
);
  import fir_mac_pkg::*;

  logic signed [COEF_W-1:0] table_q [TAPS];

  // Contents are computed at elaboration, one word per tap.
  for (genvar i = 0; i < TAPS; i++) begin : g_word
    assign table_q[i] = COEF_W'(bank_coef(BANK, i));
  end

  assign coef = table_q[addr];
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 8,
  localparam int ADDR_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] tap_sel,
  output logic [DATA_W-1:0] tap_out
);
  logic [TAPS-1:0][DATA_W-1:0] line_q;

  // Position 0 holds the newest sample.
  always_ff @(posedge clk) begin
    if (rst)           line_q[0] <= '0;
    else if (shift_en) line_q[0] <= din;
  end

  for (genvar i = 1; i < TAPS; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)           line_q[i] <= '0;
      else if (shift_en) line_q[i] <= line_q[i-1];
    end
  end

  assign tap_out = line_q[tap_sel];

  // R7: without a shift request the stored samples do not move
  p_line_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(line_q));

  // R2: after a shift the newest position holds the accepted sample
  p_line_load_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> line_q[0] == $past(din));
endmodule

// File: rtl/fir_tap_seq.sv
module fir_tap_seq #(
  parameter int TAPS = 8,
  localparam int ADDR_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  output logic              start,
  output logic              step,
  output logic              last,
  output logic [ADDR_W-1:0] tap_idx,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_TAP = ADDR_W'(TAPS - 1);

  assign start = sample_valid && !busy;
  assign step  = busy;
  assign last  = busy && (tap_idx == LAST_TAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_idx <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        tap_idx <= '0;
        busy    <= 1'b1;
      end else if (last) begin
        tap_idx <= '0;
        busy    <= 1'b0;
      end else if (step) begin
        tap_idx <= tap_idx + 1'b1;
      end
    end
  end

  // R3: the completion strobe lasts a single cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: busy falls exactly when the strobe appears
  p_busy_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R2: an idle sequencer waits at tap 0
  p_idle_tap0_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tap_idx == '0);

  // R7: a request while busy does not restart the tap walk
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> tap_idx == $past(tap_idx) + 1'b1);
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 23,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     step,
  input  logic                     last,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  result
);
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  acc_next;

  assign prod     = sample * coef;
  assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
  assign acc_next = acc_q + prod_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      result <= '0;
    end else begin
      if (start)     acc_q <= '0;
      else if (step) acc_q <= acc_next;
      if (last)      result <= acc_next;
    end
  end

  // R4: each new output begins from an empty accumulator
  p_acc_clear_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> acc_q == '0);

  // R9: the output only changes on a completing tap
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(result));
endmodule

// File: rtl/serial_fir_mac.sv
module serial_fir_mac #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 8,
  parameter int BANKS  = 4,
  parameter int ACC_W  = 23,
  localparam int ADDR_W = $clog2(TAPS),
  localparam int SEL_W  = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [SEL_W-1:0]  bank_sel,
  output logic              busy,
  output logic              result_valid,
  output logic [ACC_W-1:0]  result
);
  logic              start, step, last;
  logic [ADDR_W-1:0] tap_idx;
  logic [DATA_W-1:0] tap_sample;
  logic [SEL_W-1:0]  bank_q;
  logic signed [COEF_W-1:0] bank_word [BANKS];
  logic signed [COEF_W-1:0] coef_sel;
  logic signed [ACC_W-1:0]  result_s;

  initial assert (ACC_W >= DATA_W + COEF_W + ADDR_W)
    else $error("accumulator too narrow for the tap count");

  fir_tap_seq #(.TAPS(TAPS)) u_seq (
    .clk(clk), .rst(rst), .sample_valid(sample_valid),
    .start(start), .step(step), .last(last), .tap_idx(tap_idx),
    .busy(busy), .done(result_valid)
  );

  fir_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
    .clk(clk), .rst(rst), .shift_en(start), .din(sample_in),
    .tap_sel(tap_idx), .tap_out(tap_sample)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    fir_coef_rom #(.COEF_W(COEF_W), .TAPS(TAPS), .BANK(b)) u_rom (
      .addr(tap_idx), .coef(bank_word[b])
    );
  end

  // Bank index captured once per output computation.
  always_ff @(posedge clk) begin
    if (rst)        bank_q <= '0;
    else if (start) bank_q <= bank_sel;
  end

  assign coef_sel = bank_word[bank_q];

  fir_mac_unit #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .start(start), .step(step), .last(last),
    .sample(tap_sample), .coef(coef_sel), .result(result_s)
  );

  assign result = result_s;

  // R6: the bank in use does not change during a computation
  p_bank_hold_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(bank_q) || !busy);

  // R1: after reset every output is idle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> !busy && !result_valid && result == '0);
endmodule

// File: tb/sim_serial_fir_mac.sv
module sim_serial_fir_mac;
  logic        clk = 1'b0;
  logic        rst;
  logic        sample_valid;
  logic [7:0]  sample_in;
  logic [1:0]  bank_sel;
  logic        busy, result_valid;
  logic [22:0] result;

  int checks = 0;
  int fails  = 0;
  int line_m [8];
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_fir_mac u0 (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
    .bank_sel(bank_sel), .busy(busy), .result_valid(result_valid), .result(result)
  );

  // Coefficients written from the requirement text (R5).
  function automatic int coef_r5(int bank, int k);
    if (bank == 0) return k + 1;
    if (bank == 1) return (k == 0) ? 1 : 0;
    if (bank == 2) return (k % 2 == 0) ? 64 : -64;
    return -128;
  endfunction

  function automatic int expect_sum(int bank);
    int s = 0;
    for (int k = 0; k < 8; k++) s += line_m[k] * coef_r5(bank, k);
    return s;
  endfunction

  function automatic int res_int();
    return int'($signed(result));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sample_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) line_m[k] = 0;
  endtask

  // One accepted sample, optional noise while busy (R6, R7).
  task automatic run_one(logic [7:0] d, int bank, bit noise);
    int exp_v;
    @(negedge clk);
    sample_valid = 1'b1; sample_in = d; bank_sel = 2'(bank);
    @(posedge clk);
    for (int k = 7; k > 0; k--) line_m[k] = line_m[k-1];
    line_m[0] = int'($signed(d));
    exp_v = expect_sum(bank);
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    sample_valid = noise;
    if (noise) begin
      sample_in = 8'($urandom());
      bank_sel  = 2'(bank + 1 + ($urandom() % 3));
    end
    for (int e = 1; e <= 7; e++) begin
      @(negedge clk);
      check(result_valid == 1'b0, "R3 no early strobe", int'(result_valid), 0);
    end
    @(negedge clk);
    check(result_valid == 1'b1, "R3 strobe at eighth edge", int'(result_valid), 1);
    check(busy == 1'b0, "R3 busy falls with strobe", int'(busy), 0);
    check(res_int() == exp_v, noise ? "R4 R6 R7 sum with noise" : "R4 R5 sum",
          res_int(), exp_v);
    sample_valid = 1'b0;
    @(negedge clk);
    check(result_valid == 1'b0, "R3 strobe one cycle", int'(result_valid), 0);
    check(res_int() == exp_v, "R9 result held", res_int(), exp_v);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; sample_valid = 1'b0; sample_in = '0; bank_sel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) line_m[k] = 0;
    // R1 reset state
    check(busy == 1'b0 && result_valid == 1'b0, "R1 flags after reset", int'(busy), 0);
    check(result == '0, "R1 result after reset", res_int(), 0);

    // R5 bank 1 passes the newest sample, bank 0 weights by position
    run_one(8'd5, 1, 0);
    run_one(8'hFD, 0, 0);
    run_one(8'd100, 2, 0);

    // R8 extremes against bank 3
    for (int i = 0; i < 8; i++) run_one(8'h80, 3, 0);
    check(res_int() == 131072, "R8 all -128", res_int(), 131072);
    for (int i = 0; i < 8; i++) run_one(8'h7F, 3, 0);
    check(res_int() == -130048, "R8 all +127", res_int(), -130048);

    // R7 R6 noise during busy
    run_one(8'd17, 0, 1);
    run_one(8'hC3, 2, 1);

    // R1 reset in the middle of a computation
    @(negedge clk);
    sample_valid = 1'b1; sample_in = 8'd9; bank_sel = 2'd0;
    @(negedge clk);
    sample_valid = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();
    check(busy == 1'b0 && result_valid == 1'b0, "R1 mid reset flags", int'(busy), 0);
    check(result == '0, "R1 mid reset result", res_int(), 0);
    run_one(8'd7, 0, 0);
    check(res_int() == 7, "R1 line cleared by reset", res_int(), 7);

    // Random traffic
    for (int n = 0; n < 300; n++) begin
      int gap;
      gap = $urandom() % 4;
      repeat (gap) @(negedge clk);
      run_one(8'($urandom()), int'($urandom() % 4), bit'($urandom() % 2));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule